// File: doc/BRIEF.md
# Cache-Aware Co-Scheduling Assignment Engine

This block decides which of four cores each of four applications runs on. The cores are split into two groups of two, and each group shares one last-level cache: cores 0 and 1 use cache 0, and cores 2 and 3 use cache 1. Each application arrives with a 2-bit class that says how it uses the shared cache. A mode input says which replacement policy the caches run. Mode 0 is least-recently-used. Mode 1 is re-reference prediction. The pairing rules differ between the two modes, so the same mix of classes can give different placements.

A start pulse captures the four classes and the mode. The engine then runs one placement step per clock, and each step handles one class. Within a step it places the applications of that class in ascending index order. When all four steps are finished, the engine holds the four core indices, a map of occupied cores and an error flag, and it raises done. The error flag means that at least one application had no core that satisfied its rule and was placed on the lowest free core instead.

Top module: `coschd_engine`

## Requirements
- R1: The step sequence is the only place start matters. Start is accepted in the idle or done state. done goes high after the fourth rising edge following the edge that sampled start. It stays high until the next accepted start, and it drops on the edge that accepts that start.
- R2: The classes and mode are captured on the edge that accepts start. A start pulse, or any change of the class and mode inputs, while the four steps run has no effect on the result or on the timing.
- R3: In mode 0, each thrashing application goes to the lowest free core of the lowest cache that already holds a thrasher and still has a free core. If no such cache exists, it goes to the lowest core of the lowest completely empty cache.
- R4: In mode 1, each thrashing application goes to the lowest free core of the lowest cache that holds no thrasher yet. If every cache already holds a thrasher, it takes the lowest free core and the error flag is set.
- R5: In both modes, each core-fitting application goes to the lowest free core of the lowest cache that holds no core-fitting application yet. If no such cache exists, it takes the lowest free core and the error flag is set.
- R6: A cache-fitting application searches its preferences in order and takes the first cache that matches:
  - a half-filled cache whose occupant is core-fitting;
  - in mode 1 only, a half-filled cache whose occupant is thrashing;
  - a half-filled cache whose occupant is cache-fitting or thrashing;
  - an empty cache.
- R7: Cache-friendly applications are placed last, each on the lowest free core. They never set the error flag.
- R8: The steps run in a fixed order: thrashing, then core-fitting, then cache-fitting, then cache-friendly. Ties go to the lowest application index, then the lowest cache, then the lowest core. Class codes are 0 core-fitting, 1 thrashing, 2 cache-fitting and 3 cache-friendly. Application i uses bits [2i+1:2i] of both app_cls and app_core.
- R9: While done is high, every core holds exactly one application, core_used is all ones, and no two applications share a core index.
- R10: The error flag is cleared when start is accepted. It accumulates across the steps of one run.
- R11: After reset, done, err, core_used and app_core are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begins a placement run when the engine is idle or done |
| rrp_mode | input | 1 | 0: least-recently-used rules, 1: re-reference-prediction rules |
| app_cls | input | 8 | Four 2-bit application classes |
| app_core | output | 8 | Four 2-bit core indices, one per application |
| done | output | 1 | Placement complete; results valid |
| err | output | 1 | A fallback placement was used in the last run |
| core_used | output | 4 | One bit per core, set once an application is placed there |

## Verification
The embedded assertions check several properties on every cycle:
- each pick lands on a core that is still free;
- the placement result is a full permutation whenever done is high;
- done holds until a new start arrives;
- the captured classes stay frozen during a run;
- the friendly step never reports a fallback.

The class-specific rules depend on what the other applications in the mix are, and only the bench scenarios can show them. These rules are thrasher grouping versus spreading, core-fitting spreading, the partner tiers for cache-fitting applications, and the resulting error flag. The bench compares the engine against an independent placement model over every class mix in both modes. It also checks hand-computed placements and a start pulse injected in the middle of a run.

// File: rtl/coschd_pkg.sv
package coschd_pkg;

  // Application class codes; values are visible on the app_cls port.
  typedef enum logic [1:0] {
    CLS_CORE   = 2'd0,
    CLS_THRASH = 2'd1,
    CLS_FIT    = 2'd2,
    CLS_SHARE  = 2'd3
  } app_cls_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_THRASH = 3'd1,
    ST_CORE   = 3'd2,
    ST_FIT    = 3'd3,
    ST_SHARE  = 3'd4,
    ST_DONE   = 3'd5
  } step_e;

endpackage

// File: rtl/coschd_pick.sv
// Chooses a core for one application given the current occupancy.
module coschd_pick
  import coschd_pkg::*;
#(
  parameter int unsigned N_CACHE = 2,
  parameter int unsigned CPC     = 2,
  localparam int unsigned N_CORE = N_CACHE * CPC,
  localparam int unsigned CORE_W = $clog2(N_CORE),
  localparam int unsigned CNT_W  = $clog2(CPC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                rrp_mode,
  input  app_cls_e            cls,
  input  logic [N_CORE-1:0]   occ,
  input  logic [2*N_CORE-1:0] occ_cls,
  output logic [CORE_W-1:0]   core,
  output logic                fallback
);

  logic [CNT_W-1:0]   free_cnt [N_CACHE];
  logic [N_CACHE-1:0] has_thr, has_ccf, has_fit, has_room, all_free, half;
  logic [N_CACHE-1:0] tier [4];
  logic               found;
  int                 sel;

  // Per-cache occupancy summary
  always_comb begin
    for (int c = 0; c < N_CACHE; c++) begin
      free_cnt[c] = '0;
      has_thr[c]  = 1'b0;
      has_ccf[c]  = 1'b0;
      has_fit[c]  = 1'b0;
      for (int k = 0; k < CPC; k++) begin
        if (!occ[c*CPC+k]) begin
          free_cnt[c] = free_cnt[c] + CNT_W'(1);
        end else begin
          case (occ_cls[2*(c*CPC+k) +: 2])
            CLS_THRASH: has_thr[c] = 1'b1;
            CLS_CORE:   has_ccf[c] = 1'b1;
            CLS_FIT:    has_fit[c] = 1'b1;
            default:    ;
          endcase
        end
      end
      has_room[c] = (free_cnt[c] != '0);
      all_free[c] = (free_cnt[c] == CNT_W'(CPC));
      half[c]     = has_room[c] && !all_free[c];
    end
  end

  // Preference tiers per class and mode; tier 0 is the strongest
  always_comb begin
    for (int t = 0; t < 4; t++) tier[t] = '0;
    unique case (cls)
      CLS_THRASH: begin
        if (!rrp_mode) begin
          tier[0] = has_thr & has_room;
          tier[1] = all_free;
        end else begin
          tier[0] = ~has_thr & has_room;
        end
      end
      CLS_CORE: tier[0] = ~has_ccf & has_room;
      CLS_FIT: begin
        tier[0] = half & has_ccf;
        if (rrp_mode) tier[1] = half & has_thr;
        tier[2] = half & (has_fit | has_thr);
        tier[3] = all_free;
      end
      CLS_SHARE: ;
    endcase
  end

  // Strongest non-empty tier wins, lowest cache, then lowest free core
  always_comb begin
    found = 1'b0;
    sel   = 0;
    core  = '0;
    for (int t = 3; t >= 0; t--) begin
      if (|tier[t]) begin
        found = 1'b1;
        for (int c = N_CACHE - 1; c >= 0; c--) begin
          if (tier[t][c]) sel = c;
        end
      end
    end
    if (found) begin
      for (int k = CPC - 1; k >= 0; k--) begin
        if (!occ[sel*CPC+k]) core = CORE_W'(sel*CPC+k);
      end
    end else begin
      for (int i = N_CORE - 1; i >= 0; i--) begin
        if (!occ[i]) core = CORE_W'(i);
      end
    end
    fallback = en && !found && (cls != CLS_SHARE);
  end

  // R9: a pick never lands on an occupied core
  a_r9_pick_free_core: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !occ[core]);

endmodule

// File: rtl/coschd_step.sv
// One rule step: chains a picker per application in index order.
module coschd_step
  import coschd_pkg::*;
#(
  parameter int unsigned N_CACHE = 2,
  parameter int unsigned CPC     = 2,
  localparam int unsigned N_CORE = N_CACHE * CPC,
  localparam int unsigned CORE_W = $clog2(N_CORE)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       active,
  input  logic                       rrp_mode,
  input  app_cls_e                   step_cls,
  input  logic [2*N_CORE-1:0]        app_cls,
  input  logic [N_CORE-1:0]          occ_in,
  input  logic [2*N_CORE-1:0]        occ_cls_in,
  output logic [N_CORE-1:0]          occ_out,
  output logic [2*N_CORE-1:0]        occ_cls_out,
  output logic [N_CORE-1:0]          wr,
  output logic [CORE_W*N_CORE-1:0]   wr_core,
  output logic                       err
);

  logic [N_CORE-1:0] fb;

  for (genvar i = 0; i < N_CORE; i++) begin : g_app
    app_cls_e              my_cls;
    logic [CORE_W-1:0]     pc;
    logic [N_CORE-1:0]     occ_pre, occ_nx;
    logic [2*N_CORE-1:0]   cls_pre, cls_nx;

    if (i == 0) begin : g_first
      assign occ_pre = occ_in;
      assign cls_pre = occ_cls_in;
    end else begin : g_next
      assign occ_pre = g_app[i-1].occ_nx;
      assign cls_pre = g_app[i-1].cls_nx;
    end

    assign my_cls = app_cls_e'(app_cls[2*i +: 2]);
    assign wr[i]  = active && (my_cls == step_cls);

    coschd_pick #(.N_CACHE(N_CACHE), .CPC(CPC)) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (wr[i]),
      .rrp_mode (rrp_mode),
      .cls      (my_cls),
      .occ      (occ_pre),
      .occ_cls  (cls_pre),
      .core     (pc),
      .fallback (fb[i])
    );

    assign wr_core[CORE_W*i +: CORE_W] = pc;

    always_comb begin
      occ_nx = occ_pre;
      cls_nx = cls_pre;
      if (wr[i]) begin
        occ_nx[pc]                 = 1'b1;
        cls_nx[2*int'(pc) +: 2]    = my_cls;
      end
    end
  end

  assign occ_out     = g_app[N_CORE-1].occ_nx;
  assign occ_cls_out = g_app[N_CORE-1].cls_nx;
  assign err         = |fb;

  // R7: the friendly step only fills free cores and never falls back
  a_r7_share_no_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step_cls == CLS_SHARE) |-> (fb == '0));

endmodule

// File: rtl/coschd_ctrl.sv
// Sequencer: one rule step per clock in fixed class order.
module coschd_ctrl
  import coschd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  output logic     capture,
  output logic     active,
  output logic     done,
  output app_cls_e step_cls
);

  step_e state_q, state_d;

  assign capture = start && (state_q == ST_IDLE || state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (capture) state_d = ST_THRASH;
      ST_THRASH:        state_d = ST_CORE;
      ST_CORE:          state_d = ST_FIT;
      ST_FIT:           state_d = ST_SHARE;
      ST_SHARE:         state_d = ST_DONE;
      default:          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    active   = 1'b1;
    step_cls = CLS_SHARE;
    unique case (state_q)
      ST_THRASH: step_cls = CLS_THRASH;
      ST_CORE:   step_cls = CLS_CORE;
      ST_FIT:    step_cls = CLS_FIT;
      ST_SHARE:  step_cls = CLS_SHARE;
      default:   active   = 1'b0;
    endcase
  end

  assign done = (state_q == ST_DONE);

endmodule

// File: rtl/coschd_engine.sv
module coschd_engine
  import coschd_pkg::*;
#(
  parameter int unsigned N_CACHE = 2,
  parameter int unsigned CPC     = 2,
  localparam int unsigned N_CORE = N_CACHE * CPC,
  localparam int unsigned CORE_W = $clog2(N_CORE)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      rrp_mode,
  input  logic [2*N_CORE-1:0]       app_cls,
  output logic [CORE_W*N_CORE-1:0]  app_core,
  output logic                      done,
  output logic                      err,
  output logic [N_CORE-1:0]         core_used
);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic     capture, active;
  app_cls_e step_cls;

  coschd_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .capture  (capture),
    .active   (active),
    .done     (done),
    .step_cls (step_cls)
  );

  logic [2*N_CORE-1:0]      cls_q, cls_d;
  logic                     mode_q, mode_d;
  logic [N_CORE-1:0]        occ_q, occ_d;
  logic [2*N_CORE-1:0]      ocls_q, ocls_d;
  logic [CORE_W*N_CORE-1:0] core_q, core_d;
  logic                     err_q, err_d;
  logic                     reg_en;

  logic [N_CORE-1:0]        st_occ;
  logic [2*N_CORE-1:0]      st_ocls;
  logic [N_CORE-1:0]        st_wr;
  logic [CORE_W*N_CORE-1:0] st_core;
  logic                     st_err;

  coschd_step #(.N_CACHE(N_CACHE), .CPC(CPC)) u_step (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .active      (active),
    .rrp_mode    (mode_q),
    .step_cls    (step_cls),
    .app_cls     (cls_q),
    .occ_in      (occ_q),
    .occ_cls_in  (ocls_q),
    .occ_out     (st_occ),
    .occ_cls_out (st_ocls),
    .wr          (st_wr),
    .wr_core     (st_core),
    .err         (st_err)
  );

  assign reg_en = capture || active;

  always_comb begin
    cls_d  = cls_q;
    mode_d = mode_q;
    occ_d  = occ_q;
    ocls_d = ocls_q;
    core_d = core_q;
    err_d  = err_q;
    if (capture) begin
      cls_d  = app_cls;
      mode_d = rrp_mode;
      occ_d  = '0;
      ocls_d = '0;
      core_d = '0;
      err_d  = 1'b0;
    end else if (active) begin
      occ_d  = st_occ;
      ocls_d = st_ocls;
      err_d  = err_q || st_err;
      for (int i = 0; i < N_CORE; i++) begin
        if (st_wr[i]) core_d[CORE_W*i +: CORE_W] = st_core[CORE_W*i +: CORE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cls_q  <= '0;
      mode_q <= 1'b0;
      occ_q  <= '0;
      ocls_q <= '0;
      core_q <= '0;
      err_q  <= 1'b0;
    end else if (reg_en) begin
      cls_q  <= cls_d;
      mode_q <= mode_d;
      occ_q  <= occ_d;
      ocls_q <= ocls_d;
      core_q <= core_d;
      err_q  <= err_d;
    end
  end

  assign app_core  = core_q;
  assign err       = err_q;
  assign core_used = occ_q;

  // Checker-side view of which cores the result vector names
  logic [N_CORE-1:0] named_mask;
  always_comb begin
    named_mask = '0;
    for (int i = 0; i < N_CORE; i++) named_mask[core_q[CORE_W*i +: CORE_W]] = 1'b1;
  end

  a_r9_all_cores_used: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (&occ_q));

  a_r9_distinct_cores: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> ($countones(named_mask) == N_CORE));

  a_r1_done_holds: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !start) |=> done);

  a_r2_classes_frozen: assert property (@(posedge clk) disable iff (!rst_int_n)
    active |=> ($stable(cls_q) && $stable(mode_q)));

endmodule

// File: tb/sim_coschd_engine.sv
module sim_coschd_engine;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic       rrp_mode;
  logic [7:0] app_cls;
  logic [7:0] app_core;
  logic       done, err;
  logic [3:0] core_used;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  coschd_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rrp_mode(rrp_mode),
    .app_cls(app_cls), .app_core(app_core), .done(done), .err(err),
    .core_used(core_used)
  );

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // Reference: tier of a cache for a class (lower is better, 9 = unusable)
  function automatic int rank(int cls, bit rrp, int fr, bit ht, bit hc, bit hf);
    case (cls)
      1: begin
        if (!rrp) begin
          if (ht && fr > 0) return 0;
          if (fr == 2) return 1;
        end else if (!ht && fr > 0) return 0;
      end
      0: if (!hc && fr > 0) return 0;
      2: begin
        if (fr == 1 && hc) return 0;
        if (rrp && fr == 1 && ht) return 1;
        if (fr == 1 && (hf || ht)) return 2;
        if (fr == 2) return 3;
      end
      default: ;
    endcase
    return 9;
  endfunction

  task automatic ref_place(input logic [7:0] c, input bit rrp,
                           output logic [7:0] cores, output bit e);
    int holder[4];
    int order[4] = '{1, 0, 2, 3};
    cores = '0;
    e = 1'b0;
    foreach (holder[i]) holder[i] = -1;
    foreach (order[s]) begin
      for (int a = 0; a < 4; a++) begin
        int cl = int'(c[2*a +: 2]);
        int best = 9, bc = 0, pick = -1;
        if (cl != order[s]) continue;
        for (int cc = 0; cc < 2; cc++) begin
          int fr = 0; bit ht = 0, hc = 0, hf = 0; int r;
          for (int k = 0; k < 2; k++) begin
            int h = holder[cc*2+k];
            if (h < 0) fr++;
            else if (h == 1) ht = 1;
            else if (h == 0) hc = 1;
            else if (h == 2) hf = 1;
          end
          r = rank(cl, rrp, fr, ht, hc, hf);
          if (r < best) begin best = r; bc = cc; end
        end
        if (best < 9) begin
          for (int k = 1; k >= 0; k--) if (holder[bc*2+k] < 0) pick = bc*2+k;
        end else begin
          for (int k = 3; k >= 0; k--) if (holder[k] < 0) pick = k;
          if (cl != 3) e = 1'b1;
        end
        holder[pick] = cl;
        cores[2*a +: 2] = 2'(pick);
      end
    end
  endtask

  task automatic run(input logic [7:0] c, input bit m, input bit poke,
                     input bit use_exp, input logic [7:0] xcore, input bit xerr,
                     input string tag);
    logic [7:0] ecore; bit eerr;
    ref_place(c, m, ecore, eerr);
    if (use_exp) begin ecore = xcore; eerr = xerr; end
    @(negedge clk);
    app_cls = c; rrp_mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0; app_cls = ~c; rrp_mode = !m;   // R2: inputs change after capture
    check(done == 1'b0, $sformatf("R1 %s done after accept act %0d exp 0", tag, done));
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check(done == (k == 4),
            $sformatf("R1 %s done at step %0d act %0d exp %0d", tag, k, done, (k == 4)));
      if (poke && k == 1) start = 1'b1;   // R2: start while busy
      if (poke && k == 2) start = 1'b0;
    end
    check(app_core == ecore,
          $sformatf("%s cls %h mode %0d app_core act %h exp %h", tag, c, m, app_core, ecore));
    check(err == eerr,
          $sformatf("R10 %s cls %h mode %0d err act %0d exp %0d", tag, c, m, err, eerr));
    check(core_used == 4'hF,
          $sformatf("R9 %s core_used act %h exp f", tag, core_used));
    @(negedge clk);
    check(done == 1'b1, $sformatf("R1 %s done hold act %0d exp 1", tag, done));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; rrp_mode = 1'b0; app_cls = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 0 && err == 0 && core_used == 0 && app_core == 0,
          $sformatf("R11 reset act done %0d err %0d used %h core %h exp 0 0 0 0",
                    done, err, core_used, app_core));

    // R3 R6: mode 0 groups thrashers, fitting app joins core-fitting app; R2 poke
    run(8'h25, 1'b0, 1'b1, 1'b1, 8'hB4, 1'b0, "R3 R6 R2 grouped");
    // R4 R6: mode 1 spreads thrashers, fitting app joins a thrasher
    run(8'h25, 1'b1, 1'b0, 1'b1, 8'h78, 1'b0, "R4 R6 spread");
    // R4: three thrashers cannot spread, fallback sets err; R7 friendly last
    run(8'hD5, 1'b1, 1'b0, 1'b1, 8'hD8, 1'b1, "R4 R7 thrash overflow");
    // R5 R7 R10: core-fitting spread, err cleared from the previous run
    run(8'hF0, 1'b0, 1'b0, 1'b1, 8'hD8, 1'b0, "R5 R7 R10 core spread");
    // R6 R8: four fitting apps pair in index order
    run(8'hAA, 1'b0, 1'b0, 1'b1, 8'hE4, 1'b0, "R6 R8 all fitting");
    // R5: three core-fitting apps, fallback sets err
    run(8'hC0, 1'b0, 1'b0, 1'b1, 8'hD8, 1'b1, "R5 core overflow");

    // R8: every mix in both modes against the model
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 256; c++) begin
        run(8'(c), m[0], (c % 37) == 5, 1'b0, 8'h00, 1'b0, "R8 mix");
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule